// File: doc/BRIEF.md
# LFSR Video Timing Generator

This block produces the raster timing for a display output: a horizontal sync, a vertical sync, a display-enable window and a one-clock frame-start marker. It uses two 16-bit linear feedback shift registers as its pixel and line counters in place of binary counters, so the next-state logic of each counter is one XOR gate and a shift, whatever the raster size. Each counter starts from the all-ones state. Every timing point is programmed as the LFSR state that the counter reaches after the wanted number of steps, not as a plain count. Software or a neighbouring block does the conversion from count to state, and that conversion is outside this block.

The pixel counter advances on each clock where the pixel-clock enable is high. When it reaches its end state it reloads the seed and the line counter steps once. When the line counter also sits at its end state, it reloads and a new frame begins. A sync-control code selects between running, blanked and powered-down operation. A powered-down generator stays dark until a timing-reload strobe shows that the compare values were rewritten.

Top module: `lfsr_vtiming`

## Requirements
- R1: Each counter is a 16-bit LFSR with seed 0xFFFF. One step shifts the state left by one bit and places bit15 XOR bit4 XOR bit2 XOR bit1 in bit 0. The pixel counter steps only on clocks where `pix_en` is high, so halving the enable rate doubles every period.
- R2: A compare value for count N is the state reached after N steps from the seed. The pixel counter reloads the seed on the enabled clock where it equals `h_end`, so a line lasts N+1 enabled clocks when `h_end` encodes N.
- R3: The line counter steps once on each enabled clock that ends a line. It reloads the seed on a line end where it equals `v_end`, so a frame lasts (M+1) lines when `v_end` encodes M.
- R4: `frame_start` is high for exactly one clock, following the enabled clock on which both counters reload together.
- R5: `hsync` goes high after an enabled clock where the pixel counter equals `h_sync_on`. It goes low after one where the counter equals `h_sync_off`. If both compares match at once, low wins.
- R6: `vsync` follows the same set/clear rule as R5, using the line counter and `v_sync_on` / `v_sync_off`.
- R7: The horizontal and vertical active windows follow the set/clear rule of R5, using `h_act_on`/`h_act_off` and `v_act_on`/`v_act_off`. `de` is the AND of the two windows.
- R8: `sync_mode` 0x00 runs the generator. Any other value holds both counters at the seed and drives all four outputs low from the next clock. On a return to 0x00 the generator starts from the seed, so the first `frame_start` comes after one full frame of enabled clocks.
- R9: `sync_mode` 0x07 latches a power-down state. While it is latched the outputs stay low even if the mode goes back to 0x00. A `tmg_load` pulse sampled while the mode is not 0x07 clears the latch, and the generator restarts from the seed on the next clock.
- R10: A synchronous active-low reset clears all outputs, seeds both counters and clears the power-down latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable; counters step only when high |
| sync_mode | input | 8 | 0x00 run, 0x01 blank, 0x07 power down |
| tmg_load | input | 1 | Strobe: compare values were rewritten; clears power-down |
| h_end | input | 16 | LFSR state of the last pixel count in a line |
| h_sync_on | input | 16 | LFSR state at which hsync is set |
| h_sync_off | input | 16 | LFSR state at which hsync is cleared |
| h_act_on | input | 16 | LFSR state at which the horizontal window opens |
| h_act_off | input | 16 | LFSR state at which the horizontal window closes |
| v_end | input | 16 | LFSR state of the last line count in a frame |
| v_sync_on | input | 16 | LFSR state at which vsync is set |
| v_sync_off | input | 16 | LFSR state at which vsync is cleared |
| v_act_on | input | 16 | LFSR state at which the vertical window opens |
| v_act_off | input | 16 | LFSR state at which the vertical window closes |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
The generator is first run with a permanent pixel enable and a 20-by-9 raster, so that frame length and every window edge are checked against a model that counts in plain integers. Only correct LFSR feedback makes the encoded compares land on those integer counts. An alternating enable and then a random enable show that the counters respond to the enable and not to the raw clock. A second raster with sync set and clear on the same state, and a window opening at count zero, tells apart which edge has priority and whether the first count is handled correctly. Blanking, power-down with an early return to mode 0x00, and the reload strobe each check that the generator stays dark and then restarts from the seed.

// File: rtl/vt_pkg.sv
// Package: shared constants for the LFSR video timing generator.
// Assumes a 16-bit Fibonacci-style LFSR shifting left with taps 15,4,2,1.
package vt_pkg;
    localparam int          CW        = 16;
    localparam logic [CW-1:0] TAPS    = 16'h8016;
    localparam logic [7:0]  MODE_RUN  = 8'h00;
    localparam logic [7:0]  MODE_BLNK = 8'h01;
    localparam logic [7:0]  MODE_OFF  = 8'h07;
    localparam int          NWIN      = 4;
endpackage

// File: rtl/vt_lfsr_ctr.sv
// Module: one LFSR position counter.
// Steps on adv, reloads the all-ones seed on adv&wrap or when held.
// Assumes the tap mask gives a maximal-length sequence, so zero never occurs.
module vt_lfsr_ctr #(
    parameter int             W    = vt_pkg::CW,
    parameter logic [W-1:0]   TAPS = vt_pkg::TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         adv,
    input  logic         wrap,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] SEED = '1;

    // Advance, reload or hold the LFSR state.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            state <= SEED;
        else if (adv)
            state <= wrap ? SEED : {state[W-2:0], ^(state & TAPS)};
    end

    // R1
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/vt_window.sv
// Module: set/clear timing flag driven by LFSR compares.
// Set when the count equals on_st, cleared when it equals off_st (clear wins),
// evaluated only on enabled clocks; forced low by clr.
module vt_window #(
    parameter int W = vt_pkg::CW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] on_st,
    input  logic [W-1:0] off_st,
    output logic         flag
);
    // Update the flag from the start and end compares.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            flag <= 1'b0;
        else if (adv) begin
            if (cnt == off_st)
                flag <= 1'b0;
            else if (cnt == on_st)
                flag <= 1'b1;
        end
    end

    // R5
    off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == off_st) |=> !flag);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(flag));
endmodule

// File: rtl/vt_mode_ctl.sv
// Module: sync-control decode and power-down latch.
// Runs only in mode 0x00 with the latch clear; mode 0x07 sets the latch,
// a timing-reload strobe in any other mode clears it.
module vt_mode_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sync_mode,
    input  logic       tmg_load,
    output logic       run
);
    logic pd_q;

    // Track the power-down state between mode writes and timing reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_q <= 1'b0;
        else if (sync_mode == vt_pkg::MODE_OFF)
            pd_q <= 1'b1;
        else if (tmg_load)
            pd_q <= 1'b0;
    end

    // Run only in the normal mode while not powered down.
    always_comb run = (sync_mode == vt_pkg::MODE_RUN) && !pd_q;

    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_q && !tmg_load) |=> !run);
endmodule

// File: rtl/lfsr_vtiming.sv
// Module: LFSR-counter raster timing generator (top).
// Pixel and line counters are LFSRs; all compare inputs are LFSR states.
// Assumes compare values are changed only while the generator is not running.
module lfsr_vtiming (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_en,
    input  logic [7:0]  sync_mode,
    input  logic        tmg_load,
    input  logic [15:0] h_end,
    input  logic [15:0] h_sync_on,
    input  logic [15:0] h_sync_off,
    input  logic [15:0] h_act_on,
    input  logic [15:0] h_act_off,
    input  logic [15:0] v_end,
    input  logic [15:0] v_sync_on,
    input  logic [15:0] v_sync_off,
    input  logic [15:0] v_act_on,
    input  logic [15:0] v_act_off,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        frame_start
);
    localparam int W    = vt_pkg::CW;
    localparam int NWIN = vt_pkg::NWIN;

    logic         run;
    logic [W-1:0] h_q, v_q;
    logic         h_adv, h_wrap, v_adv, v_wrap;
    logic         fs_q;
    logic [W-1:0] w_on  [NWIN];
    logic [W-1:0] w_off [NWIN];
    logic [NWIN-1:0] w_q;

    vt_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_mode(sync_mode),
        .tmg_load (tmg_load),
        .run      (run)
    );

    // Derive counter step and reload conditions.
    always_comb begin
        h_adv  = run && pix_en;
        h_wrap = (h_q == h_end);
        v_adv  = h_adv && h_wrap;
        v_wrap = (v_q == v_end);
    end

    vt_lfsr_ctr #(.W(W)) u_hctr (
        .clk(clk), .rst_n(rst_n), .hold(!run),
        .adv(h_adv), .wrap(h_wrap), .state(h_q)
    );

    vt_lfsr_ctr #(.W(W)) u_vctr (
        .clk(clk), .rst_n(rst_n), .hold(!run),
        .adv(v_adv), .wrap(v_wrap), .state(v_q)
    );

    // Gather the compare pairs: 0 hsync, 1 h window, 2 vsync, 3 v window.
    always_comb begin
        w_on[0] = h_sync_on;  w_off[0] = h_sync_off;
        w_on[1] = h_act_on;   w_off[1] = h_act_off;
        w_on[2] = v_sync_on;  w_off[2] = v_sync_off;
        w_on[3] = v_act_on;   w_off[3] = v_act_off;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam bit IS_H = (g < 2);
        vt_window #(.W(W)) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!run),
            .adv   (h_adv),
            .cnt   (IS_H ? h_q : v_q),
            .on_st (w_on[g]),
            .off_st(w_off[g]),
            .flag  (w_q[g])
        );
    end

    // Pulse frame_start after the clock on which both counters reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fs_q <= 1'b0;
        else
            fs_q <= v_adv && v_wrap;
    end

    // Drive the outputs from the window flags.
    always_comb begin
        hsync       = w_q[0];
        de          = w_q[1] && w_q[3];
        vsync       = w_q[2];
        frame_start = fs_q;
    end

    // R4
    fs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R4
    fs_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (h_q == '1 && v_q == '1));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_adv && !v_wrap) |=> v_q != $past(v_q));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!hsync && !vsync && !de && !frame_start && h_q == '1 && v_q == '1));
endmodule

// File: tb/tb_lfsr_vtiming.sv
module tb_lfsr_vtiming;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b1;
    logic [7:0] sync_mode = 8'h00;
    logic tmg_load = 1'b0;
    logic [15:0] h_end, h_sync_on, h_sync_off, h_act_on, h_act_off;
    logic [15:0] v_end, v_sync_on, v_sync_off, v_act_on, v_act_off;
    logic hsync, vsync, de, frame_start;

    always #5 clk = ~clk;

    lfsr_vtiming dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .sync_mode(sync_mode),
        .tmg_load(tmg_load),
        .h_end(h_end), .h_sync_on(h_sync_on), .h_sync_off(h_sync_off),
        .h_act_on(h_act_on), .h_act_off(h_act_off),
        .v_end(v_end), .v_sync_on(v_sync_on), .v_sync_off(v_sync_off),
        .v_act_on(v_act_on), .v_act_off(v_act_off),
        .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 0;

    // counts programmed (plain integers)
    int HEND, HSON, HSOFF, HAON, HAOFF, VEND, VSON, VSOFF, VAON, VAOFF;

    // behavioural model state
    int  m_hc = 0, m_vc = 0;
    bit  m_hs = 0, m_vs = 0, m_hw = 0, m_vw = 0, m_fs = 0, m_pd = 0;

    function automatic logic [15:0] enc(input int n);
        int v = 16'hFFFF;
        for (int i = 0; i < n; i++)
            v = ((v << 1) | (((v >> 15) ^ (v >> 4) ^ (v >> 2) ^ (v >> 1)) & 1)) & 16'hFFFF;
        return v[15:0];
    endfunction

    task automatic program_counts(input int he, hso, hsf, hao, haf,
                                  input int ve, vso, vsf, vao, vaf);
        HEND = he; HSON = hso; HSOFF = hsf; HAON = hao; HAOFF = haf;
        VEND = ve; VSON = vso; VSOFF = vsf; VAON = vao; VAOFF = vaf;
        h_end = enc(he); h_sync_on = enc(hso); h_sync_off = enc(hsf);
        h_act_on = enc(hao); h_act_off = enc(haf);
        v_end = enc(ve); v_sync_on = enc(vso); v_sync_off = enc(vsf);
        v_act_on = enc(vao); v_act_off = enc(vaf);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, one step per clock
    always @(posedge clk) begin
        bit run, fsn;
        if (!rst_n) begin
            m_hc = 0; m_vc = 0; m_hs = 0; m_vs = 0; m_hw = 0; m_vw = 0;
            m_fs = 0; m_pd = 0;
        end else begin
            run = (sync_mode == 8'h00) && !m_pd;
            fsn = run && pix_en && m_hc == HEND && m_vc == VEND;
            if (!run) begin
                m_hc = 0; m_vc = 0; m_hs = 0; m_vs = 0; m_hw = 0; m_vw = 0;
            end else if (pix_en) begin
                if (m_hc == HSOFF) m_hs = 0; else if (m_hc == HSON) m_hs = 1;
                if (m_hc == HAOFF) m_hw = 0; else if (m_hc == HAON) m_hw = 1;
                if (m_vc == VSOFF) m_vs = 0; else if (m_vc == VSON) m_vs = 1;
                if (m_vc == VAOFF) m_vw = 0; else if (m_vc == VAON) m_vw = 1;
                if (m_hc == HEND) begin
                    m_hc = 0;
                    if (m_vc == VEND) m_vc = 0; else m_vc++;
                end else m_hc++;
            end
            m_fs = fsn;
            if (sync_mode == 8'h07) m_pd = 1;
            else if (tmg_load) m_pd = 0;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check(hsync == m_hs, "R5 hsync", hsync, m_hs);
            check(vsync == m_vs, "R6 vsync", vsync, m_vs);
            check(de == (m_hw && m_vw), "R7 de", de, m_hw && m_vw);
            check(frame_start == m_fs, "R4 frame_start", frame_start, m_fs);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // negedges until frame_start seen high; optional enable pattern
    // pat: 0 = enable high, 1 = alternate, 2 = random
    task automatic count_to_fs(input int pat, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (pat == 1) pix_en = ~pix_en;
            else if (pat == 2) pix_en = 1'($urandom);
        end while (!frame_start && n < 5000);
    endtask

    task automatic count_active(input int len, output int act);
        act = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (hsync || vsync || de || frame_start) act++;
        end
    endtask

    initial begin
        int n, act;
        program_counts(19, 1, 4, 6, 16, 8, 0, 2, 3, 7);
        repeat (3) @(negedge clk);
        // R10: reset state
        check({hsync, vsync, de, frame_start} == 4'b0, "R10 reset outputs",
              {hsync, vsync, de, frame_start}, 0);
        rst_n = 1'b1;
        cmp_on = 1;

        // R2 R3: frame length with enable always high: 20 clocks x 9 lines
        count_to_fs(0, n);
        count_to_fs(0, n);
        check(n == 180, "R2 R3 frame period", n, 180);

        // R1: alternating enable doubles the period
        count_to_fs(1, n);
        count_to_fs(1, n);
        check(n == 360, "R1 half-rate frame period", n, 360);
        pix_en = 1'b1;

        // R1: random enable, model compared every clock
        repeat (700) begin
            @(negedge clk);
            pix_en = 1'($urandom);
        end
        pix_en = 1'b1;

        // R8: blank mode holds everything dark
        sync_mode = 8'h01;
        count_active(50, act);
        check(act == 0, "R8 blank outputs low", act, 0);
        // second raster: hsync on==off (clear wins), windows from count 0
        program_counts(11, 3, 3, 0, 11, 4, 1, 4, 0, 4);
        sync_mode = 8'h00;
        count_to_fs(0, n);
        check(n == 60, "R8 restart from seed", n, 60);
        count_to_fs(0, n);
        check(n == 60, "R2 second raster period", n, 60);

        // R9: power down, then mode 0 alone does not restart
        sync_mode = 8'h07;
        repeat (3) @(negedge clk);
        sync_mode = 8'h00;
        count_active(200, act);
        check(act == 0, "R9 stays dark after power down", act, 0);
        tmg_load = 1'b1;
        @(negedge clk);
        tmg_load = 1'b0;
        count_to_fs(0, n);
        n = n + 1;
        check(n == 61, "R9 restart after reload", n, 61);
        count_to_fs(0, n);
        check(n == 60, "R3 period after reload", n, 60);

        // R10: reset mid-frame clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check({hsync, vsync, de, frame_start} == 4'b0, "R10 reset mid-run",
              {hsync, vsync, de, frame_start}, 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);

        cmp_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule